// File: doc/BRIEF.md
# Quadrant Flag Status Bus

This block publishes per-queue status for a bank of 32 queues over a narrow active-low flag bus. The queues are grouped into 4 quadrants of 8, and the bus carries one quadrant at a time. A companion index output names the quadrant on the bus, so a receiver can file each 8-bit slice in the right place.

Two options are captured while reset is held and then kept for the whole run. The first picks how quadrants are chosen. In direct selection, a strobe loads the quadrant named by an address input. In polled selection, the bus steps through the quadrants in a fixed rotation, one per clock. The second option picks what the bus carries: almost-empty status or packet-ready status. A separate discrete output reports the almost-empty state of the queue currently selected for reading. A registered drive-enable output tells the pad logic when to release the bus to high impedance, so several devices can share it.

Top module: `quad_flag_bus`

## Requirements
- R1: While `rst_n` is low at a clock edge, `flag_bus_n_o` becomes all ones, `quad_idx_o` becomes 0, `rd_ae_n_o` becomes 1 and `bus_oe_o` becomes 0.
- R2: The selection mode is taken from `cfg_poll_i` at the last rising edge with `rst_n` low (1 = polled, 0 = direct). Changes to `cfg_poll_i` while `rst_n` is high have no effect.
- R3: The bus content is taken from `cfg_pkt_i` at the last rising edge with `rst_n` low. 1 selects `pr_flags_i`, 0 selects `ae_flags_i`. Later changes to `cfg_pkt_i` have no effect.
- R4: In direct mode, a rising edge with `strobe_i` high loads `quad_addr_i` into `quad_idx_o`. The same edge loads the chosen quadrant's status into `flag_bus_n_o`. Both are visible one cycle later.
- R5: In direct mode, an edge with `strobe_i` low leaves `flag_bus_n_o` and `quad_idx_o` unchanged, even if the status inputs change.
- R6: In polled mode, the first edge after reset shows quadrant 0. Each later edge shows the next quadrant in the order 0,1,2,3,0,... `strobe_i` and `quad_addr_i` are ignored.
- R7: Bus bit i carries queue number `quad*8+i`, active low: 0 means the selected status is asserted for that queue.
- R8: `rd_ae_n_o` is registered. One cycle after an edge it equals the inverse of `ae_flags_i[rd_queue_i]` sampled at that edge, in both modes and both content options.
- R9: `bus_oe_o` is registered. One cycle after an edge it equals `bus_en_i` sampled at that edge (0 = bus released to high impedance).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; option inputs are captured while it is low |
| cfg_poll_i | input | 1 | Selection mode option (1 polled, 0 direct) |
| cfg_pkt_i | input | 1 | Content option (1 packet-ready, 0 almost-empty) |
| ae_flags_i | input | 32 | Per-queue almost-empty status, active high |
| pr_flags_i | input | 32 | Per-queue packet-ready status, active high |
| strobe_i | input | 1 | Direct-mode load strobe |
| quad_addr_i | input | 2 | Direct-mode quadrant address |
| rd_queue_i | input | 5 | Queue currently selected for reading |
| bus_en_i | input | 1 | Request to drive the flag bus |
| flag_bus_n_o | output | 8 | Active-low status of one quadrant |
| quad_idx_o | output | 2 | Quadrant shown on the flag bus |
| bus_oe_o | output | 1 | Registered drive enable for the flag bus |
| rd_ae_n_o | output | 1 | Active-low almost-empty of the read-selected queue |

## Verification
Every output of this block is one register stage from its inputs. So a strobe, a polled step, a read-queue change or a drive-enable change sampled at one rising edge shows up right after that edge and stays until the next one. The bench drives inputs on the falling edge. It advances its behavioural model at the rising edge using the inputs that were stable there, and compares every output at the following falling edge. The one exception is the first polled edge after reset, which shows quadrant 0 rather than an advanced index. The model treats it that way, and the checker starts its step check one cycle later.

// File: rtl/qfb_pkg.sv
`timescale 1ns/1ps
package qfb_pkg;

  typedef enum logic {SEL_DIRECT = 1'b0, SEL_POLL = 1'b1} sel_mode_e;
  typedef enum logic {SRC_AE = 1'b0, SRC_PR = 1'b1} flag_src_e;

  // Next quadrant in the polled rotation, wrapping at the quadrant count.
  function automatic int unsigned next_quad(input int unsigned cur, input int unsigned nquads);
    if (cur + 1 >= nquads) return 0;
    return cur + 1;
  endfunction

  // Bit position of a queue's flag within the full status vector.
  function automatic int unsigned queue_pos(input int unsigned quad, input int unsigned lane,
                                            input int unsigned per_quad);
    return quad * per_quad + lane;
  endfunction

endpackage

// File: rtl/qfb_cfg_latch.sv
`timescale 1ns/1ps
module qfb_cfg_latch
  import qfb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_poll_i,
  input  logic      cfg_pkt_i,
  output sel_mode_e mode_o,
  output flag_src_e src_o
);
  sel_mode_e mode_q;
  flag_src_e src_q;

  // Options follow their inputs only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= cfg_poll_i ? SEL_POLL : SEL_DIRECT;
      src_q  <= cfg_pkt_i  ? SRC_PR   : SRC_AE;
    end
  end

  assign mode_o = mode_q;
  assign src_o  = src_q;
endmodule

// File: rtl/qfb_slice_mux.sv
`timescale 1ns/1ps
module qfb_slice_mux #(
  parameter int unsigned NUM_QUADS = 4,
  parameter int unsigned PER_QUAD  = 8,
  localparam int unsigned NQ     = NUM_QUADS * PER_QUAD,
  localparam int unsigned QSEL_W = (NUM_QUADS > 1) ? $clog2(NUM_QUADS) : 1
) (
  input  logic [NQ-1:0]       flags_i,
  input  logic [QSEL_W-1:0]   quad_i,
  output logic [PER_QUAD-1:0] slice_o
);
  logic [PER_QUAD-1:0] slices [NUM_QUADS];

  for (genvar g = 0; g < NUM_QUADS; g++) begin : g_quad
    for (genvar b = 0; b < PER_QUAD; b++) begin : g_lane
      assign slices[g][b] = flags_i[qfb_pkg::queue_pos(g, b, PER_QUAD)];
    end
  end

  always_comb begin
    slice_o = '0;
    for (int q = 0; q < NUM_QUADS; q++) begin
      if (int'(quad_i) == q) slice_o = slices[q];
    end
  end
endmodule

// File: rtl/qfb_quad_sel.sv
`timescale 1ns/1ps
module qfb_quad_sel
  import qfb_pkg::*;
#(
  parameter int unsigned NUM_QUADS = 4,
  localparam int unsigned QSEL_W = (NUM_QUADS > 1) ? $clog2(NUM_QUADS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sel_mode_e         mode_i,
  input  logic              strobe_i,
  input  logic [QSEL_W-1:0] addr_i,
  output logic              load_o,
  output logic [QSEL_W-1:0] quad_o
);
  logic [QSEL_W-1:0] ptr_q;

  // The poll pointer names the quadrant to show at the coming edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (mode_i == SEL_POLL) begin
      ptr_q <= QSEL_W'(next_quad(int'(ptr_q), NUM_QUADS));
    end
  end

  always_comb begin
    if (mode_i == SEL_POLL) begin
      load_o = 1'b1;
      quad_o = ptr_q;
    end else begin
      load_o = strobe_i;
      quad_o = addr_i;
    end
  end
endmodule

// File: rtl/qfb_disc_flag.sv
`timescale 1ns/1ps
module qfb_disc_flag #(
  parameter int unsigned NQ = 32,
  localparam int unsigned QIDX_W = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NQ-1:0]     ae_i,
  input  logic [QIDX_W-1:0] rd_q_i,
  output logic              ae_n_o
);
  logic sel_ae;

  always_comb begin
    sel_ae = 1'b0;
    for (int i = 0; i < NQ; i++) begin
      if (int'(rd_q_i) == i) sel_ae = ae_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ae_n_o <= 1'b1;
    else        ae_n_o <= ~sel_ae;
  end
endmodule

// File: rtl/quad_flag_bus.sv
`timescale 1ns/1ps
module quad_flag_bus
  import qfb_pkg::*;
#(
  parameter int unsigned NUM_QUADS       = 4,
  parameter int unsigned QUEUES_PER_QUAD = 8,
  localparam int unsigned NQ     = NUM_QUADS * QUEUES_PER_QUAD,
  localparam int unsigned QSEL_W = (NUM_QUADS > 1) ? $clog2(NUM_QUADS) : 1,
  localparam int unsigned QIDX_W = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_poll_i,
  input  logic                       cfg_pkt_i,
  input  logic [NQ-1:0]              ae_flags_i,
  input  logic [NQ-1:0]              pr_flags_i,
  input  logic                       strobe_i,
  input  logic [QSEL_W-1:0]          quad_addr_i,
  input  logic [QIDX_W-1:0]          rd_queue_i,
  input  logic                       bus_en_i,
  output logic [QUEUES_PER_QUAD-1:0] flag_bus_n_o,
  output logic [QSEL_W-1:0]          quad_idx_o,
  output logic                       bus_oe_o,
  output logic                       rd_ae_n_o
);
  sel_mode_e                  mode;
  flag_src_e                  src;
  logic                       poll_mode;
  logic                       upd_evt;
  logic [QSEL_W-1:0]          show_quad;
  logic [NQ-1:0]              src_flags;
  logic [QUEUES_PER_QUAD-1:0] slice;

  qfb_cfg_latch u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_poll_i (cfg_poll_i),
    .cfg_pkt_i  (cfg_pkt_i),
    .mode_o     (mode),
    .src_o      (src)
  );

  assign poll_mode = (mode == SEL_POLL);
  assign src_flags = (src == SRC_PR) ? pr_flags_i : ae_flags_i;

  qfb_quad_sel #(.NUM_QUADS(NUM_QUADS)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode),
    .strobe_i (strobe_i),
    .addr_i   (quad_addr_i),
    .load_o   (upd_evt),
    .quad_o   (show_quad)
  );

  qfb_slice_mux #(.NUM_QUADS(NUM_QUADS), .PER_QUAD(QUEUES_PER_QUAD)) u_mux (
    .flags_i (src_flags),
    .quad_i  (show_quad),
    .slice_o (slice)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_bus_n_o <= '1;
      quad_idx_o   <= '0;
      bus_oe_o     <= 1'b0;
    end else begin
      bus_oe_o <= bus_en_i;
      if (upd_evt) begin
        flag_bus_n_o <= ~slice;
        quad_idx_o   <= show_quad;
      end
    end
  end

  qfb_disc_flag #(.NQ(NQ)) u_disc (
    .clk    (clk),
    .rst_n  (rst_n),
    .ae_i   (ae_flags_i),
    .rd_q_i (rd_queue_i),
    .ae_n_o (rd_ae_n_o)
  );
endmodule

// File: rtl/qfb_checker.sv
`timescale 1ns/1ps
module qfb_checker #(
  parameter int unsigned NUM_QUADS = 4,
  parameter int unsigned PER_QUAD  = 8,
  localparam int unsigned NQ     = NUM_QUADS * PER_QUAD,
  localparam int unsigned QSEL_W = (NUM_QUADS > 1) ? $clog2(NUM_QUADS) : 1,
  localparam int unsigned QIDX_W = (NQ > 1) ? $clog2(NQ) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                strobe_i,
  input logic [QSEL_W-1:0]   quad_addr_i,
  input logic [QIDX_W-1:0]   rd_queue_i,
  input logic [NQ-1:0]       ae_flags_i,
  input logic                bus_en_i,
  input logic [PER_QUAD-1:0] flag_bus_n_o,
  input logic [QSEL_W-1:0]   quad_idx_o,
  input logic                bus_oe_o,
  input logic                rd_ae_n_o,
  input logic                poll_mode,
  input logic                upd_evt
);
  logic started;
  always_ff @(posedge clk) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (flag_bus_n_o == '1 && quad_idx_o == '0 && rd_ae_n_o && !bus_oe_o));

  assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(poll_mode));

  assert_direct_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!poll_mode && strobe_i) |=> quad_idx_o == $past(quad_addr_i));

  assert_direct_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!poll_mode && !strobe_i) |=> ($stable(flag_bus_n_o) && $stable(quad_idx_o)));

  assert_poll_every_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    poll_mode |-> upd_evt);

  assert_poll_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_mode && started) |=>
      quad_idx_o == QSEL_W'((int'($past(quad_idx_o)) + 1) % NUM_QUADS));

  assert_read_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> rd_ae_n_o == !$past(ae_flags_i[rd_queue_i]));

  assert_drive_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> bus_oe_o == $past(bus_en_i));
endmodule

bind quad_flag_bus qfb_checker #(
  .NUM_QUADS (NUM_QUADS),
  .PER_QUAD  (QUEUES_PER_QUAD)
) u_qfb_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .strobe_i     (strobe_i),
  .quad_addr_i  (quad_addr_i),
  .rd_queue_i   (rd_queue_i),
  .ae_flags_i   (ae_flags_i),
  .bus_en_i     (bus_en_i),
  .flag_bus_n_o (flag_bus_n_o),
  .quad_idx_o   (quad_idx_o),
  .bus_oe_o     (bus_oe_o),
  .rd_ae_n_o    (rd_ae_n_o),
  .poll_mode    (poll_mode),
  .upd_evt      (upd_evt)
);

// File: tb/tb_quad_flag_bus.sv
`timescale 1ns/1ps
module tb_quad_flag_bus;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_poll_i = 1'b0, cfg_pkt_i = 1'b0;
  logic [31:0] ae_flags_i = '0, pr_flags_i = '0;
  logic        strobe_i = 1'b0;
  logic [1:0]  quad_addr_i = '0;
  logic [4:0]  rd_queue_i = '0;
  logic        bus_en_i = 1'b0;
  logic [7:0]  flag_bus_n_o;
  logic [1:0]  quad_idx_o;
  logic        bus_oe_o, rd_ae_n_o;

  always #2.5 clk = ~clk;

  quad_flag_bus dut (.*);

  int nvec = 0, nfail = 0;
  bit done = 0;
  string phase = "R1 reset";

  // Reference state
  int m_poll = 0, m_pkt = 0, m_ptr = 0, m_idx = 0, m_bus = 255, m_disc = 1, m_oe = 0;
  bit m_in_reset = 1;

  task automatic model_edge();
    logic [31:0] fl;
    if (!rst_n) begin
      m_poll = cfg_poll_i; m_pkt = cfg_pkt_i;
      m_ptr = 0; m_idx = 0; m_bus = 255; m_disc = 1; m_oe = 0; m_in_reset = 1;
    end else begin
      m_in_reset = 0;
      fl = m_pkt ? pr_flags_i : ae_flags_i;
      if (m_poll != 0) begin
        m_idx = m_ptr;
        m_bus = 255 - int'(fl[m_ptr*8 +: 8]);
        m_ptr = (m_ptr + 1) % 4;
      end else if (strobe_i) begin
        m_idx = quad_addr_i;
        m_bus = 255 - int'(fl[quad_addr_i*8 +: 8]);
      end
      m_disc = ae_flags_i[rd_queue_i] ? 0 : 1;
      m_oe = bus_en_i;
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s [%s] actual=%0d expected=%0d at %0t", tag, phase, act, exp, $time);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(m_in_reset ? "R1 bus" : (m_poll != 0 ? "R6 bus" : "R4 bus"), int'(flag_bus_n_o), m_bus);
    chk(m_in_reset ? "R1 idx" : (m_poll != 0 ? "R6 idx" : "R4 idx"), int'(quad_idx_o), m_idx);
    chk(m_in_reset ? "R1 rd flag" : "R8 rd flag", int'(rd_ae_n_o), m_disc);
    chk(m_in_reset ? "R1 oe" : "R9 oe", int'(bus_oe_o), m_oe);
  endtask

  task automatic randomize_in(input bit strobes);
    ae_flags_i = $urandom; pr_flags_i = $urandom;
    rd_queue_i = 5'($urandom); bus_en_i = 1'($urandom);
    quad_addr_i = 2'($urandom);
    strobe_i = strobes ? 1'($urandom) : 1'b0;
  endtask

  task automatic do_reset(input bit poll, input bit pkt);
    rst_n = 1'b0; cfg_poll_i = poll; cfg_pkt_i = pkt;
    repeat (3) cycle();
    rst_n = 1'b1;
  endtask

  initial begin
    // R1: reset state with direct mode and almost-empty content
    phase = "R1 reset state";
    ae_flags_i = 32'hFFFF_FFFF; bus_en_i = 1'b1;
    do_reset(1'b0, 1'b0);

    // R2/R3: flip options after reset; behaviour must stay direct + almost-empty
    phase = "R2 R3 options ignored after reset";
    cfg_poll_i = 1'b1; cfg_pkt_i = 1'b1;
    for (int q = 0; q < 4; q++) begin
      randomize_in(1'b0);
      strobe_i = 1'b1; quad_addr_i = 2'(q);
      cycle();
    end

    // R7: single flag at queue 10 -> quadrant 1, bit 2 low
    phase = "R7 polarity and lane order";
    ae_flags_i = 32'h0000_0400; pr_flags_i = '1; strobe_i = 1'b1; quad_addr_i = 2'd1;
    cycle();
    chk("R7 bus pattern", int'(flag_bus_n_o), 8'hFB);

    // R5: no strobe, inputs churn, bus holds
    phase = "R5 hold without strobe";
    for (int i = 0; i < 12; i++) begin
      randomize_in(1'b0);
      cycle();
      chk("R5 held idx", int'(quad_idx_o), 1);
      chk("R5 held bus", int'(flag_bus_n_o), 8'hFB);
    end

    phase = "R4 R8 R9 direct mixed";
    for (int i = 0; i < 80; i++) begin
      randomize_in(1'b1);
      cycle();
    end

    // R6 + R3: polled mode, packet-ready content, strobes ignored
    phase = "R3 R6 polled packet-ready";
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < 40; i++) begin
      randomize_in(1'b1);
      cfg_poll_i = 1'($urandom); cfg_pkt_i = 1'($urandom);
      cycle();
    end

    phase = "R6 polled almost-empty";
    do_reset(1'b1, 1'b0);
    for (int i = 0; i < 40; i++) begin
      randomize_in(1'b1);
      cycle();
    end

    phase = "R3 direct packet-ready";
    do_reset(1'b0, 1'b1);
    for (int i = 0; i < 40; i++) begin
      randomize_in(1'b1);
      cycle();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired [%s]", phase);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule